// File: doc/BRIEF.md
# Conversion-Ratio Regulation State Machine

This controller keeps the output of a switched-capacitor step-down converter inside a window of plus or minus five percent around its target. Two window-comparator bits report whether the output sits under the lower threshold (0.95 of target) or over the upper threshold (1.05 of target). A free-running divider produces a decision strobe at a fixed rate, nominally 1 MHz. On each strobe the machine holds its position or moves by one place along an ordered list of twelve converter configurations. The list runs from a ratio of one half up to about 0.9.

Each position drives a registered configuration word. The word holds a switching-frequency divider code, a series/parallel select, a bridge select and the ratio mode of the second and third stages. The first stage always runs 2:1, so it has no control bit. Positions with high output resistance switch at one half or one quarter of the full rate, so that the output voltage keeps rising by small steps from one position to the next. An enable input freezes the position, and the position index is brought out for observation.

Top module: `cr_regulator_fsm`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the position index becomes 0 and the configuration word becomes the one for position 0, and the decision divider restarts.
- R2: A decision strobe occurs on every TICK_DIV-th rising edge after reset is released, the first one on edge number TICK_DIV. The position never changes on any other edge.
- R3: At a strobe with `enable` high, `cmp_below`=1 and `cmp_above`=0, the position index rises by one.
- R4: At a strobe with `enable` high, `cmp_above`=1 and `cmp_below`=0, the position index falls by one.
- R5: At a strobe where both comparator bits are 0, the position is held.
- R6: The invalid code with both comparator bits at 1 is treated as a hold.
- R7: The position saturates: a step up at position 11 stays at 11, and a step down at position 0 stays at 0.
- R8: While `enable` is low, strobes cause no change of position. The decision divider keeps counting.
- R9: Between two consecutive edges the position index changes by at most one.
- R10: `cfg_st2_tri` equals bit 0 of the position index and `cfg_st3_tri` equals bit 1 of the position index (1 selects 3:1, 0 selects 2:1).
- R11: `cfg_series` is 1 exactly for positions 4 to 7, and `cfg_bridge` is 1 exactly for positions 8 to 11.
- R12: `cfg_div_sel` uses code 0 for full rate, 1 for half rate and 2 for quarter rate. It is 2 at positions 7 and 11, 1 at positions 3, 6 and 10, and 0 at all other positions. Code 3 never appears.
- R13: The configuration word changes on the same clock edge as the position index. No cycle shows a word that belongs to a different position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Allows position changes at decision strobes |
| cmp_below | input | 1 | Output is under the 0.95 threshold |
| cmp_above | input | 1 | Output is over the 1.05 threshold |
| state_idx | output | $clog2(NUM_STATES) | Current position in the ratio list |
| cfg_div_sel | output | 2 | Switching-frequency divider code |
| cfg_series | output | 1 | Series connection of stages |
| cfg_bridge | output | 1 | Bridge between second and third stage |
| cfg_st2_tri | output | 1 | Second stage in 3:1 mode |
| cfg_st3_tri | output | 1 | Third stage in 3:1 mode |

## Verification
The assertions assume that both comparator bits are already synchronous to `clk` and stable around each rising edge. In the real system they come from clocked comparators. The bench changes them only on falling edges. The assertions also assume that reset is held low for at least two edges before the first release, so that every past value they compare against is a reset value. The stimulus covers runs into both saturation limits, the invalid both-set code, a stretch with `enable` low, a reset in the middle of operation, and a long run of pseudo-random comparator codes.

// File: rtl/cr_ctrl_pkg.sv
// Shared configuration type and the position-to-configuration mapping.
// Assumes positions are grouped in fours: the group selects the stage
// interconnect and the place within the group selects the stage modes.
package cr_ctrl_pkg;

    localparam int DIV_FULL    = 0;
    localparam int DIV_HALF    = 1;
    localparam int DIV_QUARTER = 2;

    typedef struct packed {
        logic [1:0] div_sel;
        logic       series;
        logic       bridge;
        logic       st3_tri;
        logic       st2_tri;
    } cr_cfg_t;

    // Derive the configuration word of one position.
    function automatic cr_cfg_t cfg_of(input int unsigned idx);
        cr_cfg_t     c;
        int unsigned grp;
        int unsigned pos;
        grp       = idx / 4;
        pos       = idx % 4;
        c.st2_tri = 1'(pos % 2);
        c.st3_tri = 1'(pos / 2);
        c.series  = (grp == 1);
        c.bridge  = (grp == 2);
        if (grp >= 1 && pos == 3)
            c.div_sel = 2'(DIV_QUARTER);
        else if (pos == 3 || (grp >= 1 && pos == 2))
            c.div_sel = 2'(DIV_HALF);
        else
            c.div_sel = 2'(DIV_FULL);
        return c;
    endfunction

endpackage

// File: rtl/cr_tick_gen.sv
// Decision strobe generator: one-cycle pulse every TICK_DIV clocks.
// Assumes TICK_DIV >= 2. Runs regardless of enable.
module cr_tick_gen #(
    parameter int TICK_DIV = 200
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = $clog2(TICK_DIV);

    logic [CW-1:0] cnt;

    // Strobe on the last count of each period.
    assign tick = (cnt == CW'(TICK_DIV - 1));

    // Period counter, restarts at reset and on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // R2
    tick_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/cr_step_decode.sv
// Turns the two window-comparator bits into an up/down request.
// Assumes the bits are synchronous; the both-set code requests nothing.
module cr_step_decode (
    input  logic below,
    input  logic above,
    output logic step_up,
    output logic step_dn
);
    // Exactly one bit set gives a request; none or both give a hold.
    always_comb begin
        step_up = below & ~above;
        step_dn = above & ~below;
    end
endmodule

// File: rtl/cr_state_reg.sv
// Position register with saturation, plus the registered configuration
// word. Assumes step_up and step_dn are never both set.
module cr_state_reg
    import cr_ctrl_pkg::*;
#(
    parameter int NUM_STATES = 12,
    localparam int SW = $clog2(NUM_STATES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt,
    input  logic          step_up,
    input  logic          step_dn,
    output logic [SW-1:0] state,
    output cr_cfg_t       cfg
);
    localparam logic [SW-1:0] TOP = SW'(NUM_STATES - 1);

    logic [SW-1:0] nxt;

    // Next position: one step at a strobe, clamped at both ends.
    always_comb begin
        nxt = state;
        if (evt && step_up && state != TOP)
            nxt = state + 1'b1;
        else if (evt && step_dn && state != '0)
            nxt = state - 1'b1;
    end

    // Position and configuration word are updated on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= '0;
            cfg   <= cfg_of(0);
        end else begin
            state <= nxt;
            cfg   <= cfg_of(int'(nxt));
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (state == '0));
    // R9
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == $past(state)) || (state == $past(state) + 1'b1) ||
        ($past(state) == state + 1'b1));
    // R2
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> $stable(state));
    // R7
    in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state <= TOP);
    // R12
    div_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.div_sel != 2'd3);
endmodule

// File: rtl/cr_regulator_fsm.sv
// Top of the conversion-ratio regulator: strobe generator, comparator
// decode and position register. Assumes comparator bits are synchronous.
module cr_regulator_fsm
    import cr_ctrl_pkg::*;
#(
    parameter int TICK_DIV   = 200,
    parameter int NUM_STATES = 12,
    localparam int SW = $clog2(NUM_STATES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          cmp_below,
    input  logic          cmp_above,
    output logic [SW-1:0] state_idx,
    output logic [1:0]    cfg_div_sel,
    output logic          cfg_series,
    output logic          cfg_bridge,
    output logic          cfg_st2_tri,
    output logic          cfg_st3_tri
);
    logic    tick;
    logic    up;
    logic    dn;
    logic    evt;
    cr_cfg_t cfg;

    cr_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    cr_step_decode u_dec (
        .below(cmp_below), .above(cmp_above), .step_up(up), .step_dn(dn)
    );

    // A decision happens only on a strobe while enabled.
    assign evt = tick & enable;

    cr_state_reg #(.NUM_STATES(NUM_STATES)) u_state (
        .clk(clk), .rst_n(rst_n), .evt(evt), .step_up(up), .step_dn(dn),
        .state(state_idx), .cfg(cfg)
    );

    // Unpack the registered configuration word onto the ports.
    always_comb begin
        cfg_div_sel = cfg.div_sel;
        cfg_series  = cfg.series;
        cfg_bridge  = cfg.bridge;
        cfg_st2_tri = cfg.st2_tri;
        cfg_st3_tri = cfg.st3_tri;
    end

    // R6
    invalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cmp_below && cmp_above) |=> $stable(state_idx));
    // R8
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(state_idx));
endmodule

// File: tb/cr_regulator_fsm_tb.sv
// Bench with a behavioural reference model compared on every clock.
module cr_regulator_fsm_tb;
    localparam int D = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b1;
    logic       cmp_below = 1'b0;
    logic       cmp_above = 1'b0;
    logic [3:0] state_idx;
    logic [1:0] cfg_div_sel;
    logic       cfg_series, cfg_bridge, cfg_st2_tri, cfg_st3_tri;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    int    m_cnt = 0;
    int    m_state = 0;
    string m_tag = "R1";

    always #2.5 clk = ~clk;

    cr_regulator_fsm #(.TICK_DIV(D), .NUM_STATES(12)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cmp_below(cmp_below), .cmp_above(cmp_above),
        .state_idx(state_idx), .cfg_div_sel(cfg_div_sel),
        .cfg_series(cfg_series), .cfg_bridge(cfg_bridge),
        .cfg_st2_tri(cfg_st2_tri), .cfg_st3_tri(cfg_st3_tri)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Reference model: decision strobe count and position walk.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_cnt   = 0;
            m_state = 0;
            m_tag   = "R1";
        end else if (m_cnt == D - 1) begin
            m_cnt = 0;
            if (!enable) m_tag = "R8";
            else if (cmp_below && cmp_above) m_tag = "R6";
            else if (cmp_below) begin
                if (m_state == 11) m_tag = "R7";
                else begin m_state++; m_tag = "R3"; end
            end else if (cmp_above) begin
                if (m_state == 0) m_tag = "R7";
                else begin m_state--; m_tag = "R4"; end
            end else m_tag = "R5";
        end else begin
            m_cnt++;
            m_tag = "R2";
        end
    end

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        int ediv;
        if (cycles > 0) begin
            ediv = (m_state == 7 || m_state == 11) ? 2 :
                   (m_state == 3 || m_state == 6 || m_state == 10) ? 1 : 0;
            chk(m_tag, int'(state_idx), m_state);
            chk("R10 st2 R13", int'(cfg_st2_tri), m_state % 2);
            chk("R10 st3 R13", int'(cfg_st3_tri), (m_state / 2) % 2);
            chk("R11 series", int'(cfg_series), (m_state >= 4 && m_state <= 7) ? 1 : 0);
            chk("R11 bridge", int'(cfg_bridge), (m_state >= 8) ? 1 : 0);
            chk("R12 div", int'(cfg_div_sel), ediv);
        end
    end

    task automatic drive(input logic b, input logic a, input int ticks);
        @(negedge clk);
        cmp_below = b;
        cmp_above = a;
        repeat (ticks * D - 1) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        drive(0, 0, 2);
        drive(1, 0, 14);
        drive(1, 1, 2);
        drive(0, 1, 5);
        @(negedge clk);
        enable = 1'b0;
        drive(1, 0, 3);
        @(negedge clk);
        enable = 1'b1;
        drive(0, 1, 14);
        drive(1, 0, 6);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 60; i++) begin
            int r;
            r = $urandom_range(0, 3);
            drive(r[0], r[1], 1);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule